// File: doc/BRIEF.md
# Half-Bridge Output Short Detector

This block compares what two half-bridge phases are told to do with what their outputs actually show. Each phase has a top gate command, a bottom gate command and an enable for its drive. Each phase also has two digitized level bits for its output: near the supply rail and near ground. If a checked phase shows a level that does not fit its command, the block raises one shared short flag. Such a fault can be a short to the supply, to ground, or to the other phase.

The flag is for information only. No gate signal passes through this block, so the flag cannot turn any device off. A controller or an external latch decides what to do about it. Each time a phase's commands change, its output needs time to settle. For that reason a per-phase blanking window, `BLANK_CYCLES` clocks long (200 ns at 250 MHz by default), hides that phase's mismatches after every change. The flag is registered but not latched: it follows the current unmasked mismatch state.

Top module: `bridge_short_monitor`

## Requirements
- R1: After reset the flag is low. Every phase starts out blanked, as if its commands had changed on the last reset cycle. The flag therefore cannot rise before clock edge `BLANK_CYCLES`+1 after reset is released.
- R2: A phase is enabled, has its top command on and its bottom command off, and shows near-supply=1 with near-ground=0. That phase raises no flag.
- R3: An enabled phase with only its top command on shows any other level pair, for example near-ground=1. Once the phase is outside its window, the flag is high after the next clock edge.
- R4: An enabled phase with only its bottom command on expects near-supply=0 and near-ground=1. Any other pair, such as near-supply=1, raises the flag once the phase is outside its window.
- R5: A change in any of a phase's top, bottom or enable bits is seen at a clock edge. That phase's mismatch is then ignored at that edge and at the next `BLANK_CYCLES` edges. It first counts at edge `BLANK_CYCLES`+1.
- R6: A phase is not checked when its enable is low, when neither command is on, or when both are on.
- R7: The flag is the OR of the unmasked mismatches of all phases.
- R8: The flag is not latched. After the mismatch goes away, the flag is low after the next clock edge.
- R9: A command change inside a running window restarts that window at full length.
- R10: Each phase has its own window. A change on one phase does not mask a mismatch on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_hi | input | NUM_PHASES | Top device command per phase (1 = on) |
| gate_lo | input | NUM_PHASES | Bottom device command per phase (1 = on) |
| drive_en | input | NUM_PHASES | Effective drive enable per phase |
| lvl_sup | input | NUM_PHASES | Output sensed near supply, per phase |
| lvl_gnd | input | NUM_PHASES | Output sensed near ground, per phase |
| short_flag | output | 1 | Registered shared mismatch flag |

## Verification
The assertions assume that the command, enable and level bits are already synchronous to `clk` and stable around each rising edge. They also assume that a level pair can have any value, including both bits set. The stimulus changes every input only on falling edges. It holds each pattern long enough to cross the blanking boundary in both directions, and it includes contradictory level pairs so that "not checked" is tested against inputs that would otherwise be faults.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
    logic en;
  } cmd_t;

  typedef struct packed {
    logic sup;
    logic gnd;
  } lvl_t;

  // A phase is judged only when exactly one device is commanded and drive is on.
  function automatic logic phase_checked(cmd_t c);
    return c.en && (c.hi ^ c.lo);
  endfunction

  // Level pair expected for a checked phase: top on -> {sup,gnd}=10, bottom on -> 01.
  function automatic lvl_t expected_level(cmd_t c);
    lvl_t e;
    e.sup = c.hi;
    e.gnd = c.lo;
    return e;
  endfunction

  function automatic logic level_mismatch(cmd_t c, lvl_t l);
    return phase_checked(c) && (l != expected_level(c));
  endfunction

endpackage

// File: rtl/bsm_blanker.sv
module bsm_blanker
  import bsm_pkg::*;
#(
  parameter int BLANK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  output logic cmd_change,
  output logic blanked
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(BLANK_CYCLES);

  cmd_t          cmd_q;
  logic [CW-1:0] cnt_q;

  assign cmd_change = (cmd != cmd_q);
  assign blanked    = cmd_change || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= FULL;
    end else begin
      cmd_q <= cmd;
      if (cmd_change)
        cnt_q <= FULL;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  blank_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_change |=> blanked);

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/bsm_compare.sv
module bsm_compare
  import bsm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  lvl_t lvl,
  output logic mismatch
);
  assign mismatch = level_mismatch(cmd, lvl);

  // R6
  both_on_unchecked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.hi && cmd.lo) |-> !mismatch);

  // R6
  disabled_unchecked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.en |-> !mismatch);

endmodule

// File: rtl/bridge_short_monitor.sv
module bridge_short_monitor
  import bsm_pkg::*;
#(
  parameter int NUM_PHASES   = 2,
  parameter int BLANK_CYCLES = 50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PHASES-1:0] gate_hi,
  input  logic [NUM_PHASES-1:0] gate_lo,
  input  logic [NUM_PHASES-1:0] drive_en,
  input  logic [NUM_PHASES-1:0] lvl_sup,
  input  logic [NUM_PHASES-1:0] lvl_gnd,
  output logic                  short_flag
);
  logic [NUM_PHASES-1:0] raw_mismatch;
  logic [NUM_PHASES-1:0] phase_blanked;
  logic [NUM_PHASES-1:0] phase_change;
  logic [NUM_PHASES-1:0] live_fault;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    cmd_t c;
    lvl_t l;
    assign c = '{hi: gate_hi[p], lo: gate_lo[p], en: drive_en[p]};
    assign l = '{sup: lvl_sup[p], gnd: lvl_gnd[p]};

    bsm_blanker #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (c),
      .cmd_change (phase_change[p]),
      .blanked    (phase_blanked[p])
    );

    bsm_compare u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (c),
      .lvl      (l),
      .mismatch (raw_mismatch[p])
    );

    assign live_fault[p] = raw_mismatch[p] && !phase_blanked[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) short_flag <= 1'b0;
    else        short_flag <= |live_fault;
  end

  // R3 / R7
  flag_needs_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> $past(|raw_mismatch));

  // R8
  no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|raw_mismatch) |=> !short_flag);

  // R5
  change_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&(phase_change | ~raw_mismatch)) |=> !short_flag);

endmodule

// File: tb/sim_bridge_short_monitor.sv
module sim_bridge_short_monitor;
  localparam int NP = 2;
  localparam int B  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] gh = '0, gl = '0, en = '0, ls = '0, lg = '0;
  logic flag;

  always #2 clk = ~clk;

  bridge_short_monitor #(.NUM_PHASES(NP), .BLANK_CYCLES(B)) u0 (
    .clk(clk), .rst_n(rst_n), .gate_hi(gh), .gate_lo(gl), .drive_en(en),
    .lvl_sup(ls), .lvl_gnd(lg), .short_flag(flag)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;

  logic [2:0] prev_cmd [NP];
  int         age [NP];

  // Model per requirements: blank while age <= B (R5, R9, R10), judge per R2/R3/R4/R6.
  function automatic logic expect_fault(int p);
    logic on_top, on_bot;
    on_top = en[p] && gh[p] && !gl[p];
    on_bot = en[p] && gl[p] && !gh[p];
    if (on_top) return !(ls[p] == 1'b1 && lg[p] == 1'b0);
    if (on_bot) return !(ls[p] == 1'b0 && lg[p] == 1'b1);
    return 1'b0;
  endfunction

  task automatic drive(input logic [NP-1:0] h, l, e, s, g, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic x;
      gh = h; gl = l; en = e; ls = s; lg = g;
      x = 1'b0;
      for (int p = 0; p < NP; p++) begin
        logic [2:0] cur;
        cur = {h[p], l[p], e[p]};
        if (cur != prev_cmd[p]) begin
          age[p] = 0;
          prev_cmd[p] = cur;
        end else begin
          age[p]++;
        end
        if (age[p] > B && expect_fault(p)) x = 1'b1;
      end
      it.exp = x;
      it.tag = tag;
      q.push_back(it);
      @(negedge clk);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_checks++;
        if (flag !== it.exp) begin
          n_fail++;
          $display("FAIL %s: short_flag=%b expected=%b at %0t", it.tag, flag, it.exp, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    for (int p = 0; p < NP; p++) begin
      prev_cmd[p] = '0;
      age[p] = 0;
    end
    repeat (4) @(negedge clk);
    n_checks++;
    if (flag !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: short_flag=%b expected=0 in reset", flag);
    end
    rst_n = 1'b1;
    // R1: ph0 top on with ground level from reset release; masked for B+1 edges
    drive(2'b01, 2'b00, 2'b01, 2'b00, 2'b01, B + 8, "R1");
    // R2: matching high level
    drive(2'b01, 2'b00, 2'b01, 2'b01, 2'b00, B + 4, "R2");
    // R3: level falls to ground while top stays on
    drive(2'b01, 2'b00, 2'b01, 2'b00, 2'b01, 5, "R3");
    // R8: mismatch removed
    drive(2'b01, 2'b00, 2'b01, 2'b01, 2'b00, 4, "R8");
    // R5 then R4: bottom on, output stuck near supply
    drive(2'b00, 2'b01, 2'b01, 2'b01, 2'b00, B + 1, "R5");
    drive(2'b00, 2'b01, 2'b01, 2'b01, 2'b00, 6, "R4");
    // R9: change at mid window restarts it
    drive(2'b01, 2'b00, 2'b01, 2'b00, 2'b01, B / 2, "R9");
    drive(2'b00, 2'b01, 2'b01, 2'b11, 2'b00, B + 5, "R9");
    // R6: both on, disabled, neither on, all with odd levels
    drive(2'b01, 2'b01, 2'b01, 2'b00, 2'b00, B + 4, "R6");
    drive(2'b01, 2'b00, 2'b00, 2'b00, 2'b01, B + 4, "R6");
    drive(2'b00, 2'b00, 2'b01, 2'b01, 2'b01, B + 4, "R6");
    // R7: phase 1 alone, then both phases
    drive(2'b10, 2'b00, 2'b10, 2'b00, 2'b10, B + 4, "R7");
    drive(2'b11, 2'b00, 2'b11, 2'b00, 2'b11, B + 4, "R7");
    // R10: phase 0 changes; phase 1 fault keeps flag up
    drive(2'b10, 2'b01, 2'b11, 2'b01, 2'b10, B + 4, "R10");
    drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, B + 4, "R8");
    @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule